// File: doc/BRIEF.md
# Split Instruction/Data Set-Associative TLB

This block is a software-loaded translation buffer that keeps one storage array holding two halves: the lower half serves loads and stores, the upper half serves instruction fetches. Each half is organised as a number of ways, each with a fixed count of entries. A lookup presents an effective address, the access kind, the compare word produced by the segment stage (virtual segment identifier and abbreviated page index laid out like the first page-table word), and the key and no-execute bits from that same stage. Every way is probed at an index taken from the low page-number bits, and the block answers one cycle later with a status (granted, miss or protection violation), the real page number, the resulting read/write/execute rights and the second page-table word after its referenced and changed bits have been updated.

Software fills entries through a write port that names the target slot explicitly, and can drop every entry at once with a single invalidate strobe. The block keeps the referenced and changed bits of the matching entry current on its own, and holds back write permission on a clean page so that the first store to it traps. Walking the page table after a miss and raising the resulting exception belong to other blocks.

Top module: `split_tlb`

## Requirements
- R1: The slot probed in way w is (page index bits ea[16:12] for the default 32 entries per way) + w × entries-per-way, plus ways × entries-per-way when the access is a fetch (req_acc = 2'b10); loads (2'b00) and stores (2'b01) use the lower half. With defaults, data way 0 is slots 0–31, data way 1 is 32–63, fetch way 0 is 64–95, fetch way 1 is 96–127.
- R2: A way hits only when its stored page number equals ea[31:12], bit 31 (valid) of its first word is 1, bit 6 (hash select) of that word is 0, and the first word masked with 0x7FFFFFBF equals the request compare word masked the same way.
- R3: Rights come from bits [1:0] (PP) of the second word: key 0 gives read/write for 00, 01, 10 and read-only for 11; key 1 gives nothing for 00, read-only for 01 and 11, read/write for 10. Execute equals read unless no-execute is set. rsp_prot bit 0 is read, bit 1 write, bit 2 execute. A fetch needs execute, a load read, a store write.
- R4: Ways are examined from way 0 upward; the first way that grants ends the search. A violating way is recorded and the search goes on, so a later violating way replaces an earlier one. Status codes: 2'b00 granted, 2'b01 miss, 2'b10 violation.
- R5: After a first hit, a later hitting way whose second word differs from it under the mask 0xFFFFF07B (page number, WIMG, PP) is skipped.
- R6: On any hit, bit 8 (referenced) of the selected entry's second word is set, and rsp_pte1 returns the updated word.
- R7: If bit 7 (changed) of the selected word is clear, it is set only when the access is a store that was granted; in every other case write permission is removed from rsp_prot.
- R8: On a miss, rsp_rpn, rsp_prot and rsp_pte1 are zero and no entry changes.
- R9: A request accepted at a clock edge (req_valid and req_ready high) produces rsp_valid after that edge; a response is held unchanged until rsp_ready; req_ready is low while a response waits without rsp_ready, and while wr_en or inv_all is high.
- R10: With wr_en high, the page number and both words are written at wr_idx and take effect for lookups issued afterwards.
- R11: inv_all clears the valid bit of every entry, so all later lookups miss until entries are rewritten.
- R12: After reset no response is pending, req_ready is high, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| req_cmp | input | 32 | Compare word from the segment stage |
| req_key | input | 1 | Protection key from the segment stage |
| req_nx | input | 1 | No-execute from the segment stage |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | 00 granted, 01 miss, 10 violation |
| rsp_rpn | output | 20 | Real page number of the selected entry |
| rsp_prot | output | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| rsp_pte1 | output | 32 | Second page-table word after flag update |
| wr_en | input | 1 | Software entry write strobe |
| wr_idx | input | 7 | Slot to write |
| wr_epn | input | 20 | Effective page number to store |
| wr_pte0 | input | 32 | First page-table word to store |
| wr_pte1 | input | 32 | Second page-table word to store |
| inv_all | input | 1 | Clear every valid bit |

## Verification
Every lookup result is due in the cycle that follows the clock edge accepting it, and the referenced/changed update lands at that same edge, so a lookup issued right after sees the new flags. The bench drives inputs one time unit after a rising edge and its monitor compares responses at the falling edge only when rsp_valid and rsp_ready are both high, popping expectations in issue order, which keeps held responses under back-pressure from being counted twice. The effect of writes, invalidation and flag updates is observed through later lookups, and port-level checks of req_ready are sampled at the falling edge inside the cycle where wr_en or a stalled response is present.

// File: rtl/split_tlb_pkg.sv
`timescale 1ns/1ps
package split_tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_e;

    typedef enum logic [1:0] {
        ST_GRANT = 2'b00,
        ST_MISS  = 2'b01,
        ST_VIOL  = 2'b10
    } stat_e;

    localparam int PROT_R = 0;
    localparam int PROT_W = 1;
    localparam int PROT_X = 2;

    // first page-table word layout
    localparam int          P0_VALID_BIT = 31;
    localparam int          P0_HSEL_BIT  = 6;
    localparam logic [31:0] P0_CMP_MASK  = 32'h7FFF_FFBF;

    // second page-table word layout
    localparam int          P1_REF_BIT   = 8;
    localparam int          P1_CHG_BIT   = 7;
    localparam logic [31:0] P1_SAME_MASK = 32'hFFFF_F07B;

    typedef struct packed {
        logic        valid;
        stat_e       status;
        logic [19:0] rpn;
        logic [2:0]  prot;
        logic [31:0] pte1;
    } rsp_t;

    function automatic logic rights_ok(input logic [1:0] acc, input logic [2:0] prot);
        logic ok;
        case (acc)
            ACC_FETCH: ok = prot[PROT_X];
            ACC_STORE: ok = prot[PROT_W];
            default:   ok = prot[PROT_R];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_index_gen.sv
`timescale 1ns/1ps
module tlb_index_gen #(
    parameter int EPW      = 32,
    parameter int NUM_WAYS = 2,
    parameter int WAY      = 0,
    parameter int PGW      = 5,
    parameter int IDX_W    = 7
) (
    input  logic [PGW-1:0]   pg,
    input  logic             is_fetch,
    output logic [IDX_W-1:0] idx
);
    localparam int WAY_BASE  = WAY * EPW;
    localparam int SIDE_SIZE = NUM_WAYS * EPW;

    always_comb begin
        idx = IDX_W'(pg) + IDX_W'(WAY_BASE);
        if (is_fetch) begin
            idx = idx + IDX_W'(SIDE_SIZE);
        end
    end
endmodule

// File: rtl/tlb_way_match.sv
`timescale 1ns/1ps
module tlb_way_match
    import split_tlb_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [31:0]      req_cmp,
    input  logic [VPN_W-1:0] ent_epn,
    input  logic [31:0]      ent_pte0,
    output logic             hit
);
    logic page_eq;
    logic cmp_eq;
    logic live;

    always_comb begin
        page_eq = (ent_epn == req_vpn);
        cmp_eq  = ((ent_pte0 & P0_CMP_MASK) == (req_cmp & P0_CMP_MASK));
        live    = ent_pte0[P0_VALID_BIT] && !ent_pte0[P0_HSEL_BIT];
        hit     = live && page_eq && cmp_eq;
    end
endmodule

// File: rtl/tlb_prot_calc.sv
`timescale 1ns/1ps
module tlb_prot_calc
    import split_tlb_pkg::*;
(
    input  logic [1:0] pp,
    input  logic       key,
    input  logic       nx,
    output logic [2:0] prot
);
    logic rd;
    logic wr;

    always_comb begin
        if (!key) begin
            rd = 1'b1;
            wr = (pp != 2'b11);
        end else begin
            rd = (pp != 2'b00);
            wr = (pp == 2'b10);
        end
        prot         = '0;
        prot[PROT_R] = rd;
        prot[PROT_W] = wr;
        prot[PROT_X] = rd && !nx;
    end
endmodule

// File: rtl/split_tlb.sv
`timescale 1ns/1ps
module split_tlb
    import split_tlb_pkg::*;
#(
    parameter int EPW        = 32,
    parameter int NUM_WAYS   = 2,
    parameter int PAGE_SHIFT = 12,
    localparam int TOTAL     = 2 * NUM_WAYS * EPW,
    localparam int IDX_W     = $clog2(TOTAL),
    localparam int VPN_W     = 32 - PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_ea,
    input  logic [1:0]       req_acc,
    input  logic [31:0]      req_cmp,
    input  logic             req_key,
    input  logic             req_nx,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [1:0]       rsp_status,
    output logic [19:0]      rsp_rpn,
    output logic [2:0]       rsp_prot,
    output logic [31:0]      rsp_pte1,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_epn,
    input  logic [31:0]      wr_pte0,
    input  logic [31:0]      wr_pte1,
    input  logic             inv_all
);
    localparam int PGW   = $clog2(EPW);
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

    // storage
    logic [VPN_W-1:0] epn_q  [TOTAL];
    logic [VPN_W-1:0] epn_d  [TOTAL];
    logic [31:0]      pte0_q [TOTAL];
    logic [31:0]      pte0_d [TOTAL];
    logic [31:0]      pte1_q [TOTAL];
    logic [31:0]      pte1_d [TOTAL];
    rsp_t             st_q;
    rsp_t             st_d;

    // per-way probe results
    logic [IDX_W-1:0] way_idx  [NUM_WAYS];
    logic [31:0]      way_p1   [NUM_WAYS];
    logic [2:0]       way_prot [NUM_WAYS];
    logic             way_hit  [NUM_WAYS];
    logic             way_ok   [NUM_WAYS];

    logic is_fetch;
    logic accept;
    logic unused_ea_lo;

    assign is_fetch     = (req_acc == ACC_FETCH);
    assign unused_ea_lo = ^req_ea[PAGE_SHIFT-1:0];

    genvar w;
    generate
        for (w = 0; w < NUM_WAYS; w++) begin : g_way
            tlb_index_gen #(
                .EPW      (EPW),
                .NUM_WAYS (NUM_WAYS),
                .WAY      (w),
                .PGW      (PGW),
                .IDX_W    (IDX_W)
            ) u_idx (
                .pg       (req_ea[PAGE_SHIFT +: PGW]),
                .is_fetch (is_fetch),
                .idx      (way_idx[w])
            );

            tlb_way_match #(
                .VPN_W (VPN_W)
            ) u_match (
                .req_vpn  (req_ea[31:PAGE_SHIFT]),
                .req_cmp  (req_cmp),
                .ent_epn  (epn_q[way_idx[w]]),
                .ent_pte0 (pte0_q[way_idx[w]]),
                .hit      (way_hit[w])
            );

            assign way_p1[w] = pte1_q[way_idx[w]];

            tlb_prot_calc u_prot (
                .pp   (way_p1[w][1:0]),
                .key  (req_key),
                .nx   (req_nx),
                .prot (way_prot[w])
            );

            assign way_ok[w] = rights_ok(req_acc, way_prot[w]);
        end
    endgenerate

    // ordered way selection
    logic             found;
    logic             done;
    logic [WAY_W-1:0] sel_way;
    stat_e            sel_stat;
    logic [2:0]       sel_prot;
    logic [31:0]      sel_p1;

    always_comb begin
        found    = 1'b0;
        done     = 1'b0;
        sel_way  = '0;
        sel_stat = ST_MISS;
        sel_prot = '0;
        sel_p1   = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (!done && way_hit[i]) begin
                if (!found || ((sel_p1 & P1_SAME_MASK) == (way_p1[i] & P1_SAME_MASK))) begin
                    found    = 1'b1;
                    sel_way  = WAY_W'(i);
                    sel_prot = way_prot[i];
                    sel_p1   = way_p1[i];
                    if (way_ok[i]) begin
                        sel_stat = ST_GRANT;
                        done     = 1'b1;
                    end else begin
                        sel_stat = ST_VIOL;
                    end
                end
            end
        end
    end

    // referenced / changed handling
    logic [31:0] upd_p1;
    logic [2:0]  out_prot;

    always_comb begin
        upd_p1   = sel_p1;
        out_prot = sel_prot;
        upd_p1[P1_REF_BIT] = 1'b1;
        if (!sel_p1[P1_CHG_BIT]) begin
            if (req_acc == ACC_STORE && sel_stat == ST_GRANT) begin
                upd_p1[P1_CHG_BIT] = 1'b1;
            end else begin
                out_prot[PROT_W] = 1'b0;
            end
        end
        if (!found) begin
            upd_p1   = '0;
            out_prot = '0;
        end
    end

    assign req_ready = (!st_q.valid || rsp_ready) && !wr_en && !inv_all;
    assign accept    = req_valid && req_ready;

    // next state
    always_comb begin
        st_d   = st_q;
        epn_d  = epn_q;
        pte0_d = pte0_q;
        pte1_d = pte1_q;

        if (st_q.valid && rsp_ready) begin
            st_d.valid = 1'b0;
        end

        if (accept) begin
            st_d.valid  = 1'b1;
            st_d.status = sel_stat;
            st_d.rpn    = found ? sel_p1[31:12] : 20'd0;
            st_d.prot   = out_prot;
            st_d.pte1   = upd_p1;
            if (found) begin
                pte1_d[way_idx[sel_way]] = upd_p1;
            end
        end

        if (wr_en) begin
            epn_d[wr_idx]  = wr_epn;
            pte0_d[wr_idx] = wr_pte0;
            pte1_d[wr_idx] = wr_pte1;
        end

        if (inv_all) begin
            for (int i = 0; i < TOTAL; i++) begin
                pte0_d[i][P0_VALID_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < TOTAL; i++) begin
                epn_q[i]  <= '0;
                pte0_q[i] <= '0;
                pte1_q[i] <= '0;
            end
        end else begin
            st_q   <= st_d;
            epn_q  <= epn_d;
            pte0_q <= pte0_d;
            pte1_q <= pte1_d;
        end
    end

    assign rsp_valid  = st_q.valid;
    assign rsp_status = st_q.status;
    assign rsp_rpn    = st_q.rpn;
    assign rsp_prot   = st_q.prot;
    assign rsp_pte1   = st_q.pte1;

endmodule

// File: rtl/split_tlb_chk.sv
`timescale 1ns/1ps
module split_tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_acc,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [1:0]  rsp_status,
    input logic [19:0] rsp_rpn,
    input logic [2:0]  rsp_prot,
    input logic [31:0] rsp_pte1,
    input logic        wr_en,
    input logic        inv_all
);
    logic [1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 2'b00;
        end else if (req_valid && req_ready) begin
            acc_q <= req_acc;
        end
    end

    // R9
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R9
    hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rpn)
                                       && $stable(rsp_prot) && $stable(rsp_pte1)));

    // R9
    stall_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || inv_all) |-> !req_ready);

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b01) |-> (rsp_rpn == 20'd0 && rsp_prot == 3'd0 && rsp_pte1 == 32'd0));

    // R6
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'b01) |-> rsp_pte1[8]);

    // R3
    grant_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b00) |->
            ((acc_q == 2'b10) ? rsp_prot[2] : (acc_q == 2'b01) ? rsp_prot[1] : rsp_prot[0]));

    // R7
    store_sets_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b00 && acc_q == 2'b01) |-> rsp_pte1[7]);

    // R7
    clean_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'b01 && !rsp_pte1[7]) |-> !rsp_prot[1]);

endmodule

bind split_tlb split_tlb_chk u_chk (.*);

// File: tb/split_tlb_tb.sv
`timescale 1ns/1ps
module split_tlb_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_ea;
    logic [1:0]  req_acc;
    logic [31:0] req_cmp;
    logic        req_key;
    logic        req_nx;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [1:0]  rsp_status;
    logic [19:0] rsp_rpn;
    logic [2:0]  rsp_prot;
    logic [31:0] rsp_pte1;
    logic        wr_en;
    logic [6:0]  wr_idx;
    logic [19:0] wr_epn;
    logic [31:0] wr_pte0;
    logic [31:0] wr_pte1;
    logic        inv_all;

    always #2.5 clk = ~clk;

    split_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea), .req_acc(req_acc),
        .req_cmp(req_cmp), .req_key(req_key), .req_nx(req_nx),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_rpn(rsp_rpn), .rsp_prot(rsp_prot), .rsp_pte1(rsp_pte1),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_epn(wr_epn), .wr_pte0(wr_pte0),
        .wr_pte1(wr_pte1), .inv_all(inv_all)
    );

    localparam logic [1:0] LD = 2'b00, ST = 2'b01, IF = 2'b10;
    localparam logic [1:0] GR = 2'b00, MS = 2'b01, VI = 2'b10;
    localparam logic [31:0] P0_OK  = 32'h8000_9180;
    localparam logic [31:0] P0_H   = 32'h8000_91C0;
    localparam logic [31:0] P0_OFF = 32'h0000_9180;
    localparam logic [31:0] CMP    = 32'h0000_9180;
    localparam logic [31:0] CMP_BAD= 32'h0000_9200;

    int n_chk  = 0;
    int n_fail = 0;

    logic [1:0]  q_st   [$];
    logic [19:0] q_rpn  [$];
    logic [2:0]  q_prot [$];
    logic [31:0] q_pte1 [$];
    string       q_tag  [$];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            n_chk++;
            if (q_st.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected response: actual st=%0d expected none", rsp_status);
            end else begin
                logic [1:0]  e_st;
                logic [19:0] e_rpn;
                logic [2:0]  e_prot;
                logic [31:0] e_pte1;
                string       e_tag;
                e_st = q_st.pop_front();
                e_rpn = q_rpn.pop_front();
                e_prot = q_prot.pop_front();
                e_pte1 = q_pte1.pop_front();
                e_tag = q_tag.pop_front();
                if (rsp_status != e_st || rsp_rpn != e_rpn || rsp_prot != e_prot || rsp_pte1 != e_pte1) begin
                    n_fail++;
                    $display("FAIL %s: actual st=%0d rpn=%h prot=%b pte1=%h expected st=%0d rpn=%h prot=%b pte1=%h",
                             e_tag, rsp_status, rsp_rpn, rsp_prot, rsp_pte1, e_st, e_rpn, e_prot, e_pte1);
                end
            end
        end
    end

    task automatic look(input logic [31:0] ea, input logic [1:0] acc, input logic [31:0] cmp,
                        input logic key, input logic nx, input logic [1:0] est, input logic [19:0] erpn,
                        input logic [2:0] eprot, input logic [31:0] epte1, input string tag);
        q_st.push_back(est);
        q_rpn.push_back(erpn);
        q_prot.push_back(eprot);
        q_pte1.push_back(epte1);
        q_tag.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b1; req_ea = ea; req_acc = acc; req_cmp = cmp; req_key = key; req_nx = nx;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic put(input logic [6:0] idx, input logic [19:0] epn, input logic [31:0] p0, input logic [31:0] p1);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = idx; wr_epn = epn; wr_pte0 = p0; wr_pte1 = p1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_acc = LD; req_cmp = '0; req_key = 1'b0;
        req_nx = 1'b0; rsp_ready = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_epn = '0; wr_pte0 = '0;
        wr_pte1 = '0; inv_all = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk(req_ready == 1'b1, "R12 reset req_ready", {31'd0, req_ready}, 32'd1);
        look(32'h0000_3000, LD, CMP, 0, 0, MS, 20'h0, 3'b000, 32'h0, "R12 empty after reset");

        // data way 0, slot 3
        put(7'd3, 20'h00003, P0_OK, 32'hABCD_E002);
        look(32'h0000_3000, LD, CMP, 0, 0, GR, 20'hABCDE, 3'b101, 32'hABCD_E102, "R10 R7 load clean page");
        look(32'h0000_3000, ST, CMP, 0, 0, GR, 20'hABCDE, 3'b111, 32'hABCD_E182, "R7 granted store sets changed");
        look(32'h0000_3000, LD, CMP, 0, 0, GR, 20'hABCDE, 3'b111, 32'hABCD_E182, "R6 flags persist");
        look(32'h0000_3000, IF, CMP, 0, 0, MS, 20'h0, 3'b000, 32'h0, "R1 fetch side separate");

        // fetch way 1, slot 99
        put(7'd99, 20'h00003, P0_OK, 32'h1111_1181);
        look(32'h0000_3000, IF, CMP, 0, 0, GR, 20'h11111, 3'b111, 32'h1111_1181, "R1 fetch way1 slot");
        look(32'h0000_3000, IF, CMP, 0, 1, VI, 20'h11111, 3'b011, 32'h1111_1181, "R3 no-execute fetch");

        // hash select bit
        put(7'd5, 20'h00005, P0_H, 32'h0055_5182);
        look(32'h0000_5000, LD, CMP, 0, 0, MS, 20'h0, 3'b000, 32'h0, "R2 hash select set");
        put(7'd5, 20'h00005, P0_OK, 32'h0055_5182);
        look(32'h0000_5000, LD, CMP, 0, 0, GR, 20'h00555, 3'b111, 32'h0055_5182, "R2 hash select clear");
        look(32'h0000_3000, LD, CMP_BAD, 0, 0, MS, 20'h0, 3'b000, 32'h0, "R2 compare mismatch");
        look(32'h0002_3000, LD, CMP, 0, 0, MS, 20'h0, 3'b000, 32'h0, "R2 page mismatch");

        // protection table
        put(7'd7, 20'h00007, P0_OK, 32'h0077_7180);
        look(32'h0000_7000, LD, CMP, 1, 0, VI, 20'h00777, 3'b000, 32'h0077_7180, "R3 key1 pp00");
        look(32'h0000_7000, LD, CMP, 0, 0, GR, 20'h00777, 3'b111, 32'h0077_7180, "R3 key0 pp00");
        put(7'd8, 20'h00008, P0_OK, 32'h0088_8003);
        look(32'h0000_8000, ST, CMP, 1, 0, VI, 20'h00888, 3'b101, 32'h0088_8103, "R7 violating store leaves changed");
        look(32'h0000_8000, LD, CMP, 1, 0, GR, 20'h00888, 3'b101, 32'h0088_8103, "R3 key1 pp11 read");
        look(32'h0000_8000, ST, CMP, 0, 0, VI, 20'h00888, 3'b101, 32'h0088_8103, "R3 key0 pp11 store");
        put(7'd10, 20'h0000A, P0_OK, 32'h00AA_A181);
        look(32'h0000_A000, LD, CMP, 1, 0, GR, 20'h00AAA, 3'b101, 32'h00AA_A181, "R3 key1 pp01 load");
        look(32'h0000_A000, ST, CMP, 1, 0, VI, 20'h00AAA, 3'b101, 32'h00AA_A181, "R3 key1 pp01 store");

        // way ordering
        put(7'd12, 20'h0000C, P0_OK, 32'h00C0_C180);
        put(7'd44, 20'h0000C, P0_OK, 32'h00D0_D182);
        look(32'h0000_C000, LD, CMP, 1, 0, VI, 20'h00C0C, 3'b000, 32'h00C0_C180, "R5 inconsistent later way skipped");
        look(32'h0000_C000, LD, CMP, 0, 0, GR, 20'h00C0C, 3'b111, 32'h00C0_C180, "R4 way0 grants");
        put(7'd12, 20'h0000C, P0_OK, 32'h00C0_C002);
        put(7'd44, 20'h0000C, P0_OK, 32'h00D0_D002);
        look(32'h0000_C000, ST, CMP, 0, 0, GR, 20'h00C0C, 3'b111, 32'h00C0_C182, "R4 first grant ends search");
        put(7'd12, 20'h0000C, P0_OFF, 32'h00C0_C182);
        look(32'h0000_C000, LD, CMP, 0, 0, GR, 20'h00D0D, 3'b101, 32'h00D0_D102, "R4 way1 untouched then hit");
        put(7'd13, 20'h0000D, P0_OK, 32'h00E0_E180);
        put(7'd45, 20'h0000D, P0_OK, 32'h00E0_E000);
        look(32'h0000_D000, LD, CMP, 1, 0, VI, 20'h00E0E, 3'b000, 32'h00E0_E100, "R4 later violation replaces");

        // back-pressure
        rsp_ready = 1'b0;
        fork
            begin
                look(32'h0000_3000, LD, CMP, 0, 0, GR, 20'hABCDE, 3'b111, 32'hABCD_E182, "R9 held response A");
                look(32'h0000_7000, LD, CMP, 0, 0, GR, 20'h00777, 3'b111, 32'h0077_7180, "R9 queued response B");
            end
            begin
                repeat (5) @(negedge clk);
                chk(rsp_valid == 1'b1, "R9 response held", {31'd0, rsp_valid}, 32'd1);
                chk(req_ready == 1'b0, "R9 stall while held", {31'd0, req_ready}, 32'd0);
                @(posedge clk); #1;
                rsp_ready = 1'b1;
            end
        join

        // write stalls requests
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = 7'd20; wr_epn = 20'h00014; wr_pte0 = P0_OK; wr_pte1 = 32'h0014_0182;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 no accept during write", {31'd0, req_ready}, 32'd0);
        @(posedge clk); #1;
        wr_en = 1'b0;
        look(32'h0001_4000, LD, CMP, 0, 0, GR, 20'h00140, 3'b111, 32'h0014_0182, "R10 written slot 20");

        // invalidate all
        @(posedge clk); #1;
        inv_all = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 no accept during invalidate", {31'd0, req_ready}, 32'd0);
        @(posedge clk); #1;
        inv_all = 1'b0;
        look(32'h0000_3000, LD, CMP, 0, 0, MS, 20'h0, 3'b000, 32'h0, "R11 data entry gone");
        look(32'h0000_3000, IF, CMP, 0, 0, MS, 20'h0, 3'b000, 32'h0, "R11 fetch entry gone");
        look(32'h0001_4000, LD, CMP, 0, 0, MS, 20'h0, 3'b000, 32'h0, "R11 R8 slot 20 gone");

        repeat (4) @(posedge clk);
        chk(q_st.size() == 0, "R9 all responses seen", q_st.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule